// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block gives a host a narrow register window into a downstream bus's configuration space and I/O port space. Software first loads a 32-bit target address into an address register. It then reads or writes one of two data windows. A data-window access launches exactly one downstream cycle, either a configuration cycle or an I/O port cycle. The byte enables of that cycle come from the host access size and the low bits of the window offset. The same address register serves both kinds of cycle.

The host side is a 32-bit register bus with a request and acknowledge handshake. The host raises `host_req` and holds the request fields until it sees `host_ack`, which is a one-cycle pulse, and drops the request at once. Data is lane-positioned: a byte at lane 2 travels on bits 23:16. The downstream side uses a plain request and response handshake.

Before each downstream request, the block drives the new address, cycle kind, byte enables and write data for one idle cycle. This prevents a new address from reaching the bus before the request that owns it. A window read stalls the host until the downstream response arrives. A response flagged as an error completes the access with all-ones read data.

The controller has four states:
- `ST_IDLE` waits for a request. It moves to `ST_GUARD` on a data-window hit, or to `ST_DONE` on any other offset.
- `ST_GUARD` is the idle address cycle. It always moves on to `ST_ISSUE`.
- `ST_ISSUE` holds `dn_req` high until `dn_rsp_valid`, then moves to `ST_DONE`.
- `ST_DONE` acknowledges the host and returns to `ST_IDLE`.

Top module: `cfg_port_window`

## Requirements
- R1: The address register sits at host offset 0x064 and resets to 0. A write updates only the byte lanes its access selects, and a read returns all 32 bits.
- R2: An access to offset 0x068 starts a configuration cycle. The cycle address is the address register's bits 23:2 placed at the same positions, with bits 1:0 forced to 0 and bits 31:24 forced to 0. Register bits 23:16 are the bus number and bits 15:8 the device/function.
- R3: `dn_kind` encodes the cycle type: 0 is an I/O cycle, 1 is a configuration cycle for bus 0 (register bits 23:16 equal 0), and 2 is a configuration cycle for any other bus.
- R4: An access to offset 0x06C starts an I/O port cycle. Its address is the address register's bits 15:0 passed unchanged, with the upper 16 bits zero.
- R5: `host_size` encodes the access width: 0 is a byte, 1 a halfword, 2 or 3 a word. A byte enables the lane named by address bits 1:0. A halfword enables lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1. A word enables all four lanes.
- R6: In the cycle before `dn_req` rises, `dn_addr`, `dn_kind`, `dn_be`, `dn_we` and `dn_wdata` already carry their final values while `dn_req` is low. They stay unchanged while `dn_req` waits for a response.
- R7: A window access stalls the host until the response: `host_ack` rises in the cycle after `dn_rsp_valid` is taken. Read data appears on the enabled lanes, other lanes read 0, and write data is forwarded only on the enabled lanes.
- R8: A response with `dn_rsp_err` set completes the access with `host_rdata` equal to all ones.
- R9: An access to any other offset raises no downstream request and leaves the address register unchanged. It is acknowledged in the next cycle, and a read returns 0.
- R10: `host_ack` is high for exactly one cycle per access. Register and unmapped accesses are acknowledged in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 12 | Host byte offset |
| host_size | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Lane-positioned write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| dn_req | output | 1 | Downstream cycle request |
| dn_kind | output | 2 | 0 I/O, 1 configuration on bus 0, 2 configuration on another bus |
| dn_addr | output | 32 | Downstream cycle address |
| dn_be | output | 4 | Downstream byte enables |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data, zero on disabled lanes |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_err | input | 1 | Downstream error flag, valid with dn_rsp_valid |
| dn_rdata | input | 32 | Downstream read data, valid with dn_rsp_valid |

## Verification
An access is accepted at the clock edge that samples `host_req` in the idle state, and each result has a fixed due cycle after that edge.
- For a register or unmapped access, `host_ack` and its data are due one cycle after acceptance.
- For a window access, the downstream fields are due one cycle after acceptance, with `dn_req` still low.
- `dn_req` is due two cycles after acceptance and stays high for every wait cycle the responder inserts.
- `host_ack` is due exactly one cycle after the cycle in which the response is presented.

The bench drives on the falling edge and steps through each of these cycles one by one. At every one it compares the ports with values its own model derives from the requirements. Latencies of zero, a few and many cycles show that the stall tracks the response and not a fixed count.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

    typedef enum logic [1:0] {
        DN_IO   = 2'd0,
        DN_CFG0 = 2'd1,
        DN_CFG1 = 2'd2
    } dn_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GUARD,
        ST_ISSUE,
        ST_DONE
    } cpw_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/cpw_lane_sel.sv
module cpw_lane_sel #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int LW    = $clog2(NB)
) (
    input  logic [1:0]        size,
    input  logic [LW-1:0]     lane_off,
    output logic [NB-1:0]     be,
    output logic [DATA_W-1:0] mask
);
    import cpw_pkg::*;

    always_comb begin
        unique case (size)
            SZ_BYTE: be = NB'(1) << lane_off;
            SZ_HALF: be = NB'(3) << (lane_off & ~LW'(1));
            default: be = '1;
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_mask
        assign mask[8*i +: 8] = {8{be[i]}};
    end

endmodule

// File: rtl/cpw_addr_reg.sv
module cpw_addr_reg #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NB-1:0]     wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (wr_be[i]) addr_q[8*i +: 8] <= wr_data[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/cpw_dn_map.sv
module cpw_dn_map (
    input  logic [23:0]            areg,
    input  logic                   is_io,
    output logic [31:0]            map_addr,
    output cpw_pkg::dn_kind_e      map_kind
);
    import cpw_pkg::*;

    always_comb begin
        if (is_io) begin
            map_addr = {16'h0000, areg[15:0]};
            map_kind = DN_IO;
        end else begin
            map_addr = {8'h00, areg[23:2], 2'b00};
            map_kind = (areg[23:16] == 8'h00) ? DN_CFG0 : DN_CFG1;
        end
    end

endmodule

// File: rtl/cfg_port_window.sv
module cfg_port_window #(
    parameter int          OFF_W    = 12,
    parameter logic [11:0] OFF_AREG = 12'h064,
    parameter logic [11:0] OFF_CFG  = 12'h068,
    parameter logic [11:0] OFF_IO   = 12'h06C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [OFF_W-1:0] host_addr,
    input  logic [1:0]       host_size,
    input  logic [31:0]      host_wdata,
    output logic             host_ack,
    output logic [31:0]      host_rdata,
    output logic             dn_req,
    output logic [1:0]       dn_kind,
    output logic [31:0]      dn_addr,
    output logic [3:0]       dn_be,
    output logic             dn_we,
    output logic [31:0]      dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic             dn_rsp_err,
    input  logic [31:0]      dn_rdata
);
    import cpw_pkg::*;

    localparam int DATA_W = 32;
    localparam int NB     = DATA_W / 8;
    localparam int LW     = $clog2(NB);

    cpw_state_e state, state_nx;

    logic              hit_areg, hit_cfg, hit_io, accept;
    logic [NB-1:0]     sel_be;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] addr_q;
    logic [31:0]       map_addr;
    dn_kind_e          map_kind;

    logic [NB-1:0]     be_q;
    logic [DATA_W-1:0] mask_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [31:0]       daddr_q;
    dn_kind_e          kind_q;
    logic [DATA_W-1:0] rdata_q;

    assign hit_areg = host_addr[OFF_W-1:LW] == OFF_AREG[OFF_W-1:LW];
    assign hit_cfg  = host_addr[OFF_W-1:LW] == OFF_CFG[OFF_W-1:LW];
    assign hit_io   = host_addr[OFF_W-1:LW] == OFF_IO[OFF_W-1:LW];
    assign accept   = (state == ST_IDLE) && host_req;

    cpw_lane_sel #(.DATA_W(DATA_W)) u_lane (
        .size     (host_size),
        .lane_off (host_addr[LW-1:0]),
        .be       (sel_be),
        .mask     (sel_mask)
    );

    cpw_addr_reg #(.DATA_W(DATA_W)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && hit_areg && host_we),
        .wr_be   (sel_be),
        .wr_data (host_wdata),
        .addr_q  (addr_q)
    );

    cpw_dn_map u_map (
        .areg     (addr_q[23:0]),
        .is_io    (hit_io),
        .map_addr (map_addr),
        .map_kind (map_kind)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (host_req) state_nx = (hit_cfg || hit_io) ? ST_GUARD : ST_DONE;
            ST_GUARD: state_nx = ST_ISSUE;
            ST_ISSUE: if (dn_rsp_valid) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Datapath capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q    <= '0;
            mask_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            daddr_q <= '0;
            kind_q  <= DN_IO;
            rdata_q <= '0;
        end else if (accept) begin
            be_q    <= sel_be;
            mask_q  <= sel_mask;
            we_q    <= host_we;
            wdata_q <= host_wdata & sel_mask;
            daddr_q <= map_addr;
            kind_q  <= map_kind;
            rdata_q <= (hit_areg && !host_we) ? addr_q : '0;
        end else if (state == ST_ISSUE && dn_rsp_valid) begin
            rdata_q <= dn_rsp_err ? '1 : (we_q ? '0 : (dn_rdata & mask_q));
        end
    end

    // Outputs
    always_comb begin
        dn_req     = (state == ST_ISSUE);
        host_ack   = (state == ST_DONE);
        host_rdata = rdata_q;
        dn_kind    = kind_q;
        dn_addr    = daddr_q;
        dn_be      = be_q;
        dn_we      = we_q;
        dn_wdata   = wdata_q;
    end

    // R6: fields settled one cycle before the request rises
    a_r6_guard_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> $stable(dn_addr) && $stable(dn_kind) && $stable(dn_be)
                          && $stable(dn_wdata) && $stable(dn_we));

    // R6: fields held while waiting
    a_r6_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_rsp_valid |=> dn_req && $stable(dn_addr) && $stable(dn_be)
                                    && $stable(dn_kind));

    // R10: acknowledge is a single-cycle pulse
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R8: error response gives all ones
    a_r8_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_rsp_valid && dn_rsp_err |=> host_ack && (host_rdata == '1));

    // R3: type-0 cycles only for bus 0
    a_r3_bus0_kind: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && (dn_kind == DN_CFG0) |-> dn_addr[23:16] == 8'h00);

    // R2: configuration addresses are dword aligned
    a_r2_cfg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && (dn_kind != DN_IO) |-> dn_addr[1:0] == 2'b00);

    // R5: a request always enables at least one lane
    a_r5_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> $countones(dn_be) > 0);

    // R7: no acknowledge while a downstream request is open
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> !host_ack);

endmodule

// File: tb/cfg_port_window_bench.sv
module cfg_port_window_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_we;
    logic [11:0] host_addr;
    logic [1:0]  host_size;
    logic [31:0] host_wdata;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        dn_req;
    logic [1:0]  dn_kind;
    logic [31:0] dn_addr;
    logic [3:0]  dn_be;
    logic        dn_we;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid, dn_rsp_err;
    logic [31:0] dn_rdata;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] model_areg = 32'h0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_window u_cfg_port_window (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .dn_req(dn_req), .dn_kind(dn_kind), .dn_addr(dn_addr), .dn_be(dn_be),
        .dn_we(dn_we), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rdata(dn_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0: return 4'b0001 << off;
            2'd1: return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ref_mask(input logic [3:0] be);
        logic [31:0] m = 32'h0;
        for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic access(input logic we, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int lat, input bit err,
                          input logic [31:0] rsp, output logic [31:0] rdo);
        logic [3:0]  be;
        logic [31:0] m, ea, er;
        logic [1:0]  ek;
        bit is_cfg, is_io, is_areg;
        be = ref_be(sz, a[1:0]);
        m  = ref_mask(be);
        is_cfg  = (a[11:2] == 10'h01A);
        is_io   = (a[11:2] == 10'h01B);
        is_areg = (a[11:2] == 10'h019);
        @(negedge clk);
        chk(host_ack == 1'b0, "R10 ack low between accesses", {31'h0, host_ack}, 32'h0);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        if (is_cfg || is_io) begin
            if (is_io) begin
                ea = {16'h0, model_areg[15:0]}; ek = 2'd0;
            end else begin
                ea = {8'h0, model_areg[23:2], 2'b00};
                ek = (model_areg[23:16] == 8'h0) ? 2'd1 : 2'd2;
            end
            chk(dn_req == 1'b0, "R6 guard cycle req low", {31'h0, dn_req}, 32'h0);
            chk(dn_addr == ea, is_io ? "R4 io address" : "R2 cfg address", dn_addr, ea);
            chk(dn_kind == ek, "R3 cycle kind", {30'h0, dn_kind}, {30'h0, ek});
            chk(dn_be == be, "R5 byte enables", {28'h0, dn_be}, {28'h0, be});
            chk(dn_we == we, "R7 write flag", {31'h0, dn_we}, {31'h0, we});
            if (we) chk(dn_wdata == (wd & m), "R7 write lanes", dn_wdata, wd & m);
            @(negedge clk);
            chk(dn_req == 1'b1, "R6 req after guard", {31'h0, dn_req}, 32'h1);
            chk(dn_addr == ea, "R6 address held", dn_addr, ea);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(dn_req == 1'b1 && host_ack == 1'b0 && dn_addr == ea,
                    "R7 stall while waiting", {30'h0, dn_req, host_ack}, 32'h2);
            end
            dn_rsp_valid = 1'b1; dn_rsp_err = err; dn_rdata = rsp;
            @(negedge clk);
            dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0; dn_rdata = 32'h0;
            er = err ? 32'hFFFF_FFFF : (we ? 32'h0 : (rsp & m));
            chk(host_ack == 1'b1 && dn_req == 1'b0, "R7 ack after response",
                {30'h0, dn_req, host_ack}, 32'h1);
            chk(host_rdata == er, err ? "R8 error data" : "R7 read lanes", host_rdata, er);
        end else begin
            er = (is_areg && !we) ? model_areg : 32'h0;
            chk(host_ack == 1'b1, "R10 register ack next cycle", {31'h0, host_ack}, 32'h1);
            chk(dn_req == 1'b0, "R9 no downstream cycle", {31'h0, dn_req}, 32'h0);
            chk(host_rdata == er, is_areg ? "R1 address readback" : "R9 unmapped reads zero",
                host_rdata, er);
            if (is_areg && we)
                for (int i = 0; i < 4; i++) if (be[i]) model_areg[8*i +: 8] = wd[8*i +: 8];
        end
        rdo = host_rdata;
        host_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_size = '0;
        host_wdata = '0; dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0; dn_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(host_ack == 1'b0 && dn_req == 1'b0, "R10 reset outputs idle",
            {30'h0, dn_req, host_ack}, 32'h0);
        // R1: reset value, full write, readback
        access(1'b0, 12'h064, 2'd2, 32'h0, 0, 0, 0, rd);
        access(1'b1, 12'h064, 2'd2, 32'hAB01_2340, 0, 0, 0, rd);
        access(1'b0, 12'h064, 2'd2, 32'h0, 0, 0, 0, rd);
        // R2 R3: bus 1 word config read, type 1
        access(1'b0, 12'h068, 2'd2, 32'h0, 0, 0, 32'hDEAD_BEEF, rd);
        // R1: byte write lane 2 only, bus 0 now
        access(1'b1, 12'h066, 2'd0, 32'h0000_0000, 0, 0, 0, rd);
        access(1'b1, 12'h064, 2'd1, 32'h0000_0A17, 0, 0, 0, rd);
        access(1'b0, 12'h064, 2'd2, 32'h0, 0, 0, 0, rd);
        // R3 R5 R7: bus 0, byte read lane 2, unaligned offset cleared
        access(1'b0, 12'h06A, 2'd0, 32'h0, 2, 0, 32'h1234_5678, rd);
        // R5 R7: halfword write upper half
        access(1'b1, 12'h06B, 2'd1, 32'hCAFE_F00D, 1, 0, 0, rd);
        // R4: I/O port cycles
        access(1'b1, 12'h064, 2'd2, 32'h0000_03F9, 0, 0, 0, rd);
        access(1'b0, 12'h06D, 2'd0, 32'h0, 0, 0, 32'hA5A5_A5A5, rd);
        access(1'b1, 12'h06C, 2'd3, 32'h8765_4321, 3, 0, 0, rd);
        access(1'b0, 12'h06C, 2'd1, 32'h0, 20, 0, 32'h1111_2222, rd);
        // R8: error responses
        access(1'b0, 12'h068, 2'd2, 32'h0, 4, 1, 32'h0000_0001, rd);
        access(1'b0, 12'h06C, 2'd0, 32'h0, 0, 1, 32'h0, rd);
        // R9: unmapped offsets ignored
        access(1'b1, 12'h070, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, rd);
        access(1'b1, 12'h060, 2'd2, 32'h1234_5678, 0, 0, 0, rd);
        access(1'b0, 12'h070, 2'd2, 32'h0, 0, 0, 0, rd);
        access(1'b0, 12'h064, 2'd2, 32'h0, 0, 0, 0, rd);
        @(negedge clk);
        chk(host_ack == 1'b0 && dn_req == 1'b0, "R10 quiet at end",
            {30'h0, dn_req, host_ack}, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule